// File: doc/BRIEF.md
# Byte-Stream to Flash Word Packer

This block sits in front of a flash word-programming engine. It takes a write request given as a start byte address and a byte length, receives the payload one byte at a time, and issues aligned 32-bit word writes to the engine. Flash programming can only clear bits. Byte lanes of a word that carry no payload are therefore sent as 0xFF, and the engine can program a whole word without disturbing the bytes next to the payload. No byte enables are needed.

A request is presented while `req_ready` is high. A request of zero bytes finishes at once without any write. A request that would reach past the end of the device is refused before any byte is taken. Otherwise the packer fills a word, hands it to the engine, and waits for the engine's completion. A failed word ends the transfer immediately. When the transfer ends, a one-cycle `done_o` pulse reports the outcome. `commit_count` then holds the number of payload bytes that were actually programmed.

Top module: `byte_word_packer`

## Requirements
- R1: Every word write uses an address whose two low bits are zero. For a start address that is not a multiple of 4, the first word goes to the start address with its two low bits cleared.
- R2: In the first word, lanes below the start offset hold 0xFF. The following lanes take payload bytes until the word is full or the payload ends, and any lanes still unused hold 0xFF.
- R3: Between the first and the last word, every word holds four payload bytes and sits 4 bytes above the previous word.
- R4: If fewer than 4 payload bytes remain for the last word, they occupy its lowest lanes and the other lanes hold 0xFF.
- R5: Byte packing is little-endian. Lane 0 is `wr_data[7:0]` and lane 3 is `wr_data[31:24]`, and earlier bytes of the stream go to lower lanes.
- R6: `commit_count` is cleared when a request is taken. After each successful word it grows by the number of payload bytes in that word, so a completed transfer reports its length.
- R7: When `wr_fail` is high together with `wr_done`, the transfer stops. `done_o` pulses with `status_o` = 2'b01, no further word is issued, no further byte is accepted, and `commit_count` counts only the words before the failed one.
- R8: A request with `req_addr + req_len` greater than the device size is refused. `done_o` pulses with `status_o` = 2'b10, and no byte is accepted and no word is issued. A request that ends exactly at the device end is carried out.
- R9: A request with `req_len` = 0 produces `done_o` with `status_o` = 2'b00 and `commit_count` = 0, and no word is issued.
- R10: Once raised, `wr_req` stays high with `wr_addr` and `wr_data` unchanged until `wr_done`. `in_ready` is never high while `wr_req` is high.
- R11: After reset, `req_ready` is 1, and `wr_req`, `in_ready`, `done_o` and `commit_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Payload length in bytes |
| req_ready | output | 1 | Packer idle, request can be taken |
| in_valid | input | 1 | Payload byte present |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Packer accepts a payload byte |
| wr_req | output | 1 | Word write request to the programming engine |
| wr_addr | output | ADDR_W | Aligned word byte address |
| wr_data | output | 32 | Word contents, unused lanes 0xFF |
| wr_done | input | 1 | Engine finished the current word |
| wr_fail | input | 1 | Qualifies wr_done: the word failed |
| done_o | output | 1 | One-cycle transfer end pulse |
| status_o | output | 2 | 00 done, 01 word failed, 10 refused |
| commit_count | output | LEN_W | Payload bytes programmed so far |

## Verification
The bench goes after offsets where the head word and the payload end coincide. A packer that pads only one side would leave the upper lane holding stale data instead of 0xFF. A request ending exactly at the device end must still be carried out, and one byte more must be refused; an off-by-one range test would flip one of the two. A failure on a middle word checks that the count excludes that word and that no bytes are drained afterwards. A packer that counted padded lanes would report multiples of 4 instead of the true length.

// File: rtl/pk_pkg.sv
package pk_pkg;

  typedef enum logic [1:0] {
    PK_IDLE  = 2'd0,
    PK_FILL  = 2'd1,
    PK_WRITE = 2'd2
  } pk_state_e;

  localparam logic [1:0] PK_ST_OK     = 2'b00;
  localparam logic [1:0] PK_ST_WFAIL  = 2'b01;
  localparam logic [1:0] PK_ST_REJECT = 2'b10;

  // Clear the lane-select bits of a byte address.
  function automatic logic [31:0] word_base(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  // True when the byte range [a, a+n) lies inside a device of 'size' bytes.
  function automatic logic range_fits(input logic [31:0] a, input logic [31:0] n,
                                      input logic [31:0] size);
    logic [32:0] span_end;
    span_end = {1'b0, a} + {1'b0, n};
    return span_end <= {1'b0, size};
  endfunction

endpackage

// File: rtl/pk_word_asm.sv
module pk_word_asm #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic [$clog2(LANES)-1:0]  start_lane,
  input  logic                      load,
  input  logic [LANE_W-1:0]         din,
  output logic [LANES*LANE_W-1:0]   word_o,
  output logic [$clog2(LANES)-1:0]  lane_o,
  output logic [$clog2(LANES+1)-1:0] fill_o
);
  localparam int LIDX_W = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES+1);

  logic [LIDX_W-1:0] lane_q;
  logic [CNT_W-1:0]  fill_q;
  logic [LANE_W-1:0] lane_byte [LANES];

  // One register per byte lane; an unloaded lane keeps the all-ones pad.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   lane_byte[g] <= '1;
      else if (clear)                               lane_byte[g] <= '1;
      else if (load && lane_q == LIDX_W'(g))        lane_byte[g] <= din;
    end
    assign word_o[g*LANE_W +: LANE_W] = lane_byte[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      fill_q <= '0;
    end else if (clear) begin
      lane_q <= start_lane;
      fill_q <= '0;
    end else if (load) begin
      lane_q <= lane_q + 1'b1;
      fill_q <= fill_q + 1'b1;
    end
  end

  assign lane_o = lane_q;
  assign fill_o = fill_q;

  // A word never carries more payload bytes than it has lanes.
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(LANES));

  // A fresh word starts fully padded.
  p_fresh_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (word_o == '1) && (fill_o == '0));

endmodule

// File: rtl/pk_commit_cnt.sv
module pk_commit_cnt #(
  parameter int W     = 16,
  parameter int ADD_W = 3,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [ADD_W-1:0] add_val,
  output logic [W-1:0]     count
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (clr)     count_q <= '0;
    else if (add_en)  count_q <= count_q + W'(add_val);
  end

  assign count = count_q;

  // Between clears the count moves up by at most one word's worth per cycle.
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count_q - $past(count_q)) <= W'(STEP));

endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
  import pk_pkg::*;
#(
  parameter int          ADDR_W    = 22,
  parameter int          LEN_W     = 16,
  parameter int unsigned DEV_BYTES = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_done,
  input  logic              wr_fail,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [LEN_W-1:0]  commit_count
);
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int LIDX_W = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES+1);

  pk_state_e         state_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [LEN_W-1:0]  remain_q;
  logic              done_q;
  logic [1:0]        status_q;

  logic [LIDX_W-1:0] lane;
  logic [CNT_W-1:0]  fill;
  logic [31:0]       word;

  // Named events, used by the control path and by the assertions.
  logic start_zero, start_rej, start_ok;
  logic byte_take, word_last_byte;
  logic word_commit, word_abort, next_word;
  logic asm_clear;
  logic [LIDX_W-1:0] asm_start_lane;
  logic [31:0] req_addr32, req_len32;

  assign req_addr32 = 32'(req_addr);
  assign req_len32  = 32'(req_len);

  assign req_ready  = (state_q == PK_IDLE);
  assign in_ready   = (state_q == PK_FILL);
  assign wr_req     = (state_q == PK_WRITE);

  assign start_zero = req_ready && req_valid && (req_len == '0);
  assign start_rej  = req_ready && req_valid && (req_len != '0) &&
                      !range_fits(req_addr32, req_len32, 32'(DEV_BYTES));
  assign start_ok   = req_ready && req_valid && (req_len != '0) &&
                      range_fits(req_addr32, req_len32, 32'(DEV_BYTES));

  assign byte_take      = in_ready && in_valid;
  assign word_last_byte = byte_take &&
                          ((lane == LIDX_W'(LANES-1)) || (remain_q == LEN_W'(1)));
  assign word_commit    = wr_req && wr_done && !wr_fail;
  assign word_abort     = wr_req && wr_done && wr_fail;
  assign next_word      = word_commit && (remain_q != '0);

  assign asm_clear      = start_ok || next_word;
  assign asm_start_lane = start_ok ? req_addr[LIDX_W-1:0] : '0;

  pk_word_asm #(.LANES(LANES), .LANE_W(LANE_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (asm_clear),
    .start_lane (asm_start_lane),
    .load       (byte_take),
    .din        (in_data),
    .word_o     (word),
    .lane_o     (lane),
    .fill_o     (fill)
  );

  pk_commit_cnt #(.W(LEN_W), .ADD_W(CNT_W), .STEP(LANES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_ok || start_zero || start_rej),
    .add_en  (word_commit),
    .add_val (fill),
    .count   (commit_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PK_IDLE;
      waddr_q  <= '0;
      remain_q <= '0;
      done_q   <= 1'b0;
      status_q <= PK_ST_OK;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PK_IDLE: begin
          if (start_zero) begin
            done_q   <= 1'b1;
            status_q <= PK_ST_OK;
          end else if (start_rej) begin
            done_q   <= 1'b1;
            status_q <= PK_ST_REJECT;
          end else if (start_ok) begin
            waddr_q  <= ADDR_W'(word_base(req_addr32));
            remain_q <= req_len;
            state_q  <= PK_FILL;
          end
        end
        PK_FILL: begin
          if (byte_take) remain_q <= remain_q - 1'b1;
          if (word_last_byte) state_q <= PK_WRITE;
        end
        PK_WRITE: begin
          if (word_abort) begin
            done_q   <= 1'b1;
            status_q <= PK_ST_WFAIL;
            state_q  <= PK_IDLE;
          end else if (next_word) begin
            waddr_q <= waddr_q + ADDR_W'(LANES);
            state_q <= PK_FILL;
          end else if (word_commit) begin
            done_q   <= 1'b1;
            status_q <= PK_ST_OK;
            state_q  <= PK_IDLE;
          end
        end
        default: state_q <= PK_IDLE;
      endcase
    end
  end

  assign wr_addr  = waddr_q;
  assign wr_data  = word;
  assign done_o   = done_q;
  assign status_o = status_q;

  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_addr[1:0] == 2'b00));

  p_write_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && in_ready));

  p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_abort |=> (done_o && status_o == PK_ST_WFAIL && !wr_req && !in_ready));

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |=> (done_o && status_o == PK_ST_REJECT && !wr_req && !in_ready));

  p_empty_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_zero |=> (done_o && status_o == PK_ST_OK && commit_count == '0 && !wr_req));

endmodule

// File: tb/byte_word_packer_tb_top.sv
module byte_word_packer_tb_top;
  localparam int ADDR_W = 22;
  localparam int LEN_W  = 16;
  localparam int DEV    = 32'h0040_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic req_ready, in_ready, wr_req, done_o;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0] wr_data;
  logic wr_done = 1'b0;
  logic wr_fail = 1'b0;
  logic [1:0] status_o;
  logic [LEN_W-1:0] commit_count;

  always #4 clk = ~clk;

  byte_word_packer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_ready(req_ready), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .wr_fail(wr_fail), .done_o(done_o), .status_o(status_o),
    .commit_count(commit_count));

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Payload source, driven by the feeder.
  logic [7:0] src [0:63];
  int feed_idx = 0;
  int feed_base = 0;
  int feed_lim = 0;

  always @(posedge clk) if (in_valid && in_ready) feed_idx <= feed_idx + 1;

  always @(negedge clk) begin
    in_valid <= (feed_idx < feed_lim);
    in_data  <= (feed_idx < feed_lim) ? src[feed_idx - feed_base] : 8'h00;
  end

  // Programming engine model: answers each word after a short wait.
  int nw = 0;
  int fail_target = -1;
  int wait_c = 0;
  int stable_err = 0;
  logic [ADDR_W-1:0] log_addr [0:63];
  logic [31:0]       log_data [0:63];
  logic [ADDR_W-1:0] cap_addr;
  logic [31:0]       cap_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      wr_done <= 1'b0;
      wr_fail <= 1'b0;
      wait_c  <= 0;
    end else if (wr_done) begin
      wr_done <= 1'b0;
      wr_fail <= 1'b0;
    end else if (wr_req) begin
      if (in_ready) stable_err <= stable_err + 1;
      if (wait_c == 0) begin
        cap_addr <= wr_addr;
        cap_data <= wr_data;
        wait_c   <= 1;
      end else if (wait_c == 2) begin
        if (cap_addr != wr_addr || cap_data != wr_data) stable_err <= stable_err + 1;
        log_addr[nw % 64] <= wr_addr;
        log_data[nw % 64] <= wr_data;
        wr_done <= 1'b1;
        wr_fail <= (nw == fail_target);
        nw      <= nw + 1;
        wait_c  <= 0;
      end else begin
        wait_c <= wait_c + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reset_state_test();
    check(req_ready == 1'b1, "R11", "req_ready", req_ready, 1);
    check(wr_req == 1'b0 && in_ready == 1'b0, "R11", "wr_req/in_ready", {wr_req, in_ready}, 0);
    check(done_o == 1'b0, "R11", "done_o", done_o, 0);
    check(commit_count == '0, "R11", "commit_count", commit_count, 0);
  endtask

  // Runs one request and checks every word, the count, the status and the drain.
  task automatic run_xfer(input int a, input int n, input int fail_rel, input string tag);
    int base, fb, nexp, nwritten, exp_cnt, off, p, tmo, stable0;
    bit rej, failing;
    logic [1:0] exp_st;
    logic [31:0] exp_w;
    string wt;
    off = a & 3;
    for (int i = 0; i < 64; i++) src[i] = 8'(8'h11 + i * 13 + a);
    @(negedge clk);
    base = nw;
    stable0 = stable_err;
    fail_target = (fail_rel < 0) ? -1 : base + fail_rel;
    fb = feed_idx;
    feed_base = fb;
    feed_lim  = fb + n;
    req_addr  = ADDR_W'(a);
    req_len   = LEN_W'(n);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    tmo = 0;
    while (!done_o && tmo < 2000) begin
      @(negedge clk);
      tmo++;
    end
    feed_lim = feed_idx;
    check(done_o == 1'b1, tag, "done seen", done_o, 1);

    rej  = (a + n > DEV);
    nexp = (n == 0 || rej) ? 0 : (off + n + 3) / 4;
    failing = (fail_rel >= 0 && fail_rel < nexp);
    nwritten = failing ? fail_rel + 1 : nexp;
    exp_st = rej ? 2'b10 : (failing ? 2'b01 : 2'b00);
    exp_cnt = 0;
    for (int k = 0; k < nwritten; k++) begin
      exp_w = '0;
      for (int l = 0; l < 4; l++) begin
        p = k * 4 + l - off;
        if (p >= 0 && p < n) begin
          exp_w[l*8 +: 8] = src[p];
          if (!(failing && k == fail_rel)) exp_cnt++;
        end else begin
          exp_w[l*8 +: 8] = 8'hFF;
        end
      end
      wt = (k == 0) ? "R2 R5" : ((k == nexp - 1) ? "R4 R5" : "R3 R5");
      check(log_addr[(base + k) % 64] == ADDR_W'((a & ~3) + 4 * k), (k == 0) ? "R1" : "R3",
            "word address", log_addr[(base + k) % 64], (a & ~3) + 4 * k);
      check(log_data[(base + k) % 64] == exp_w, wt, "word data", log_data[(base + k) % 64], exp_w);
    end
    check(nw - base == nwritten, failing ? "R7" : (rej ? "R8" : (n == 0 ? "R9" : "R3")),
          "word writes issued", nw - base, nwritten);
    check(status_o == exp_st, failing ? "R7" : (rej ? "R8" : (n == 0 ? "R9" : "R6")),
          "status", status_o, exp_st);
    check(commit_count == LEN_W'(exp_cnt), failing ? "R7" : "R6", "committed bytes",
          commit_count, exp_cnt);
    check(feed_idx - fb == (failing ? (nwritten * 4 - off < n ? nwritten * 4 - off : n) : (rej ? 0 : n)),
          failing ? "R7" : "R8", "bytes drained", feed_idx - fb, n);
    check(stable_err == stable0, "R10", "write held stable, no byte during write",
          stable_err - stable0, 0);
    fail_target = -1;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_aligned();        run_xfer(32'h100, 8, -1, "R3");  endtask
  task automatic test_head_short();     run_xfer(32'h201, 2, -1, "R2");  endtask
  task automatic test_head_body_tail(); run_xfer(32'h303, 10, -1, "R4"); endtask
  task automatic test_tail_only();      run_xfer(32'h400, 6, -1, "R4");  endtask
  task automatic test_mid_failure();    run_xfer(32'h502, 12, 1, "R7");  endtask
  task automatic test_first_failure();  run_xfer(32'h601, 5, 0, "R7");   endtask
  task automatic test_past_end();       run_xfer(DEV - 4, 5, -1, "R8");  endtask
  task automatic test_exact_end();      run_xfer(DEV - 4, 4, -1, "R8");  endtask
  task automatic test_zero_len();       run_xfer(32'h700, 0, -1, "R9");  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_state_test();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    reset_state_test();
    test_aligned();
    test_head_short();
    test_head_body_tail();
    test_tail_only();
    test_mid_failure();
    test_first_failure();
    test_past_end();
    test_exact_end();
    test_zero_len();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule